// File: doc/BRIEF.md
# Block Floating-Point Scale Tracker

This block sets the normalisation between the passes of a multi-pass FFT that works in block floating point. While a pass runs, it looks at every complex butterfly result on a stream input. For each result it counts the redundant sign bits in the real part and in the imaginary part. It keeps the smallest count seen in the pass, which marks the result of largest magnitude. When the pass ends, it turns that count into a left-shift amount. The memory read path applies that shift to every word before the next pass, so that the largest result again fills the whole word.

The block adds up the shifts over the whole transform. When the transform ends it presents the total as a 4-bit scale code. A growth mode, sampled when a transform starts, selects between two schemes. In 3-bit growth overflow cannot happen, and the total may reach 15. In 2-bit growth the datapath can report overflow, the total stops at 14, and code 15 means overflow. While overflow is flagged, an output tells the output stage to force every frequency bin to zero. The butterfly arithmetic and the memories sit outside this block.

Top module: `bfp_scale_tracker`

## Requirements
- R1: Reset state. While `rst_n` is low at a clock edge, the following outputs are 0 after that edge: `pass_shift`, `scale_code`, `scale_done` and `bins_zero`.
- R2: Sign-bit count. The redundant sign-bit count of a 16-bit word is the number of bits below the MSB that equal the MSB, counted downward from bit 14 until the first bit that differs. Its range is 0 to 15; for example 0x0001 counts 14, 0xF800 counts 4 and 0x4000 counts 0. The tracked value is the minimum of this count over the real and imaginary parts of every result with `res_valid` high during the pass.
- R3: A `pass_end` pulse sets `pass_shift`, from the next edge onward, to the smallest of three values: the tracked minimum, 4, and the budget left under the cap. `pass_shift` holds that value until the next `pass_end` or `xform_start`.
- R4: An `xform_start` pulse sets `pass_shift` to 0 from the next edge onward, so no shift is applied before the first pass.
- R5: In 3-bit growth mode (`grow_mode`=1 at `xform_start`), the cumulative shift total never exceeds 15.
- R6: In 2-bit growth mode (`grow_mode`=0 at `xform_start`), the cumulative shift total never exceeds 14.
- R7: In 2-bit mode, a result with both `res_valid` and `res_ovf` high sets `bins_zero`. The flag stays set until the next `xform_start`. While it is set, each `pass_end` gives a shift of 0, and the scale code reported at the end of the transform is 15.
- R8: In 3-bit mode, `res_ovf` is ignored: `bins_zero` stays 0, and the shifts follow R3.
- R9: An `xform_end` pulse ends the final pass in place of `pass_end`. It loads `scale_code` with the total, or with 15 after an overflow, and sets `scale_done`. The next `xform_start` clears both.
- R10: A `pass_start` pulse clears the tracked minimum to 15, so results from earlier passes have no effect on the next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grow_mode | input | 1 | Growth scheme, sampled at `xform_start`: 1 = 3-bit, 0 = 2-bit |
| xform_start | input | 1 | Pulse at the start of a transform |
| xform_end | input | 1 | Pulse at the end of the final pass |
| pass_start | input | 1 | Pulse at the start of each pass |
| pass_end | input | 1 | Pulse at the end of every pass except the final one |
| res_valid | input | 1 | A butterfly result is present |
| res_ovf | input | 1 | The present result overflowed |
| res_re | input | 16 | Real part of the result, two's complement |
| res_im | input | 16 | Imaginary part of the result, two's complement |
| pass_shift | output | 3 | Left shift to apply before the next pass |
| scale_code | output | 4 | Total shift, or 15 after an overflow |
| scale_done | output | 1 | `scale_code` is valid |
| bins_zero | output | 1 | Overflow occurred; force all output bins to zero |

## Verification
The hardest situation to reach is the point where the budget under the cap, not the per-pass limit of four, decides the shift. The total must sit exactly one partial step below 14 or 15 at the moment a pass asks for more. The stimulus gets there with passes of tiny results, each worth a full shift of four. These are followed by a pass that is cut back to the remainder and then by a pass that earns nothing. A second hard case is overflow in the middle of a pass in 2-bit mode. It has to zero that pass's shift and the final code, and the same stimulus in 3-bit mode must leave both untouched.

// File: rtl/bfp_pkg.sv
// Package: shared types for the block floating-point scale tracker.
// Assumes nothing beyond IEEE 1800-2017.
package bfp_pkg;
    // Word-growth scheme chosen for a whole transform.
    typedef enum logic {
        GROW_2BIT = 1'b0,
        GROW_3BIT = 1'b1
    } growth_e;
endpackage

// File: rtl/bfp_sign_count.sv
// Module: bfp_sign_count
// Counts the redundant sign bits of one two's-complement word: the run of bits
// below the MSB that equal the MSB. Purely combinational.
// Assumes W >= 2 and that CW bits can hold W-1.
module bfp_sign_count #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] rsb
);
    logic run;

    // Walk down from bit W-2 while the bits still match the sign.
    always_comb begin
        rsb = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (word[i] == word[W-1])) begin
                rsb = rsb + CW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bfp_pass_min.sv
// Module: bfp_pass_min
// Keeps the smallest sign-bit count seen in the current pass. min_now already
// includes the result presented in this cycle, so a pass end that coincides
// with the last result still counts that result.
// Assumes pass_start arrives once before the first result of every pass.
module bfp_pass_min #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pass_start,
    input  logic          res_valid,
    input  logic [CW-1:0] rsb_re,
    input  logic [CW-1:0] rsb_im,
    output logic [CW-1:0] min_now
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] min_q;
    logic [CW-1:0] base;
    logic [CW-1:0] pair_min;

    // Combine this cycle's result with the running minimum.
    always_comb begin
        base     = pass_start ? CNT_MAX : min_q;
        pair_min = (rsb_re < rsb_im) ? rsb_re : rsb_im;
        min_now  = base;
        if (res_valid && (pair_min < base)) begin
            min_now = pair_min;
        end
    end

    // Register the running minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= CNT_MAX;
        end else begin
            min_q <= min_now;
        end
    end

    AST_TRACK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start && !res_valid |=> min_q == CNT_MAX); // R10
    AST_MIN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !pass_start |=> min_q <= $past(min_q)); // R2
endmodule

// File: rtl/bfp_shift_accum.sv
// Module: bfp_shift_accum
// Turns the tracked minimum into a per-pass shift, adds the shifts into a
// running total under a cap chosen by the growth mode, tracks overflow, and
// reports the final scale code.
// Assumes xform_end takes the place of pass_end on the final pass.
module bfp_shift_accum
    import bfp_pkg::*;
#(
    parameter int CW        = 4,
    parameter int MAX_SHIFT = 4,
    parameter int SW        = $clog2(MAX_SHIFT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xform_start,
    input  logic          xform_end,
    input  logic          pass_end,
    input  logic          grow_mode,
    input  logic          res_valid,
    input  logic          res_ovf,
    input  logic [CW-1:0] min_now,
    output logic [SW-1:0] pass_shift,
    output logic [CW-1:0] scale_code,
    output logic          scale_done,
    output logic          bins_zero
);
    localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] STEP_MAX = CW'(MAX_SHIFT);

    growth_e       mode_q;
    logic [CW-1:0] total_q;
    logic          ovf_q;
    logic [CW-1:0] cap;
    logic [CW-1:0] room;
    logic [CW-1:0] step;
    logic          ovf_next;

    // Work out the budget left and the shift that this pass earns.
    always_comb begin
        cap      = (mode_q == GROW_3BIT) ? CODE_MAX : CODE_MAX - CW'(1);
        room     = (total_q >= cap) ? '0 : cap - total_q;
        ovf_next = ovf_q | (res_valid & res_ovf & (mode_q == GROW_2BIT));
        step     = min_now;
        if (step > STEP_MAX) step = STEP_MAX;
        if (step > room)     step = room;
        if (ovf_next)        step = '0;
    end

    // Sequence the per-transform state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= GROW_2BIT;
            total_q    <= '0;
            ovf_q      <= 1'b0;
            pass_shift <= '0;
            scale_code <= '0;
            scale_done <= 1'b0;
        end else if (xform_start) begin
            mode_q     <= growth_e'(grow_mode);
            total_q    <= '0;
            ovf_q      <= 1'b0;
            pass_shift <= '0;
            scale_code <= '0;
            scale_done <= 1'b0;
        end else begin
            ovf_q <= ovf_next;
            if (pass_end) begin
                pass_shift <= SW'(step);
                total_q    <= total_q + step;
            end
            if (xform_end) begin
                scale_code <= ovf_next ? CODE_MAX : total_q;
                scale_done <= 1'b1;
            end
        end
    end

    assign bins_zero = ovf_q;

    AST_SHIFT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pass_shift <= SW'(MAX_SHIFT)); // R3
    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        xform_start |=> pass_shift == '0); // R4
    AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= cap); // R5 R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !xform_start |=> ovf_q); // R7
    AST_OVF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && pass_end && !xform_start |=> pass_shift == '0); // R7
    AST_NO_OVF_3BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == GROW_3BIT |-> !ovf_q); // R8
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        xform_start |=> !scale_done); // R9
endmodule

// File: rtl/bfp_scale_tracker.sv
// Module: bfp_scale_tracker (top)
// Block floating-point scale tracker for a multi-pass FFT. It counts sign bits
// on both parts of each result, keeps the pass minimum, and derives the
// inter-pass shift, the total scale code and the overflow blanking.
// Assumes the pulses are one cycle wide and come from the same clock domain.
module bfp_scale_tracker #(
    parameter int DATA_W    = 16,
    parameter int MAX_SHIFT = 4,
    parameter int CW        = $clog2(DATA_W),
    parameter int SW        = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grow_mode,
    input  logic              xform_start,
    input  logic              xform_end,
    input  logic              pass_start,
    input  logic              pass_end,
    input  logic              res_valid,
    input  logic              res_ovf,
    input  logic [DATA_W-1:0] res_re,
    input  logic [DATA_W-1:0] res_im,
    output logic [SW-1:0]     pass_shift,
    output logic [CW-1:0]     scale_code,
    output logic              scale_done,
    output logic              bins_zero
);
    logic [DATA_W-1:0] comp [2];
    logic [CW-1:0]     rsb  [2];
    logic [CW-1:0]     min_now;

    assign comp[0] = res_re;
    assign comp[1] = res_im;

    // One sign counter for each component of the complex result.
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        bfp_sign_count #(.W(DATA_W), .CW(CW)) u_cnt (
            .word (comp[g]),
            .rsb  (rsb[g])
        );
    end

    bfp_pass_min #(.CW(CW)) u_min (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_start (pass_start),
        .res_valid  (res_valid),
        .rsb_re     (rsb[0]),
        .rsb_im     (rsb[1]),
        .min_now    (min_now)
    );

    bfp_shift_accum #(.CW(CW), .MAX_SHIFT(MAX_SHIFT), .SW(SW)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .xform_start (xform_start),
        .xform_end   (xform_end),
        .pass_end    (pass_end),
        .grow_mode   (grow_mode),
        .res_valid   (res_valid),
        .res_ovf     (res_ovf),
        .min_now     (min_now),
        .pass_shift  (pass_shift),
        .scale_code  (scale_code),
        .scale_done  (scale_done),
        .bins_zero   (bins_zero)
    );
endmodule

// File: tb/sim_bfp_scale_tracker.sv
// Bench for bfp_scale_tracker: a table of 3-bit-mode passes, then directed
// tests for reset, the 2-bit cap, overflow and the ignored overflow input.
module sim_bfp_scale_tracker;
    logic        clk = 1'b0;
    logic        rst_n, grow_mode, xform_start, xform_end, pass_start, pass_end;
    logic        res_valid, res_ovf;
    logic [15:0] res_re, res_im;
    logic [2:0]  pass_shift;
    logic [3:0]  scale_code;
    logic        scale_done, bins_zero;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    bfp_scale_tracker u0 (
        .clk(clk), .rst_n(rst_n), .grow_mode(grow_mode), .xform_start(xform_start),
        .xform_end(xform_end), .pass_start(pass_start), .pass_end(pass_end),
        .res_valid(res_valid), .res_ovf(res_ovf), .res_re(res_re), .res_im(res_im),
        .pass_shift(pass_shift), .scale_code(scale_code), .scale_done(scale_done),
        .bins_zero(bins_zero)
    );

    // {re1, im1, re2, im2, expected shift}; one pass each, 3-bit mode
    localparam logic [66:0] VEC [7] = '{
        {16'h0800, 16'h1000, 16'hF800, 16'hFFFF, 3'd2}, // R2 min from imag: 2
        {16'h0100, 16'h0001, 16'hFFFF, 16'hFFFF, 3'd4}, // R10 fresh min 6, R3 cap 4
        {16'h4000, 16'h0001, 16'h0001, 16'h0001, 3'd0}, // R2 full-scale word
        {16'hC000, 16'h2000, 16'h0001, 16'h0001, 3'd1}, // R2 negative word
        {16'h0001, 16'h0001, 16'h0001, 16'h0001, 3'd4}, // R3 total 11
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 3'd4}, // R5 total 15
        {16'h0001, 16'h0001, 16'h0001, 16'h0001, 3'd0}  // R5 budget used up
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_xf(input logic mode);
        @(negedge clk); grow_mode = mode; xform_start = 1'b1;
        @(negedge clk); xform_start = 1'b0;
    endtask

    task automatic run_pass(input logic [15:0] a, b, c, d, input logic ovf);
        @(negedge clk); pass_start = 1'b1;
        @(negedge clk); pass_start = 1'b0; res_valid = 1'b1; res_ovf = ovf;
        res_re = a; res_im = b;
        @(negedge clk); res_re = c; res_im = d;
        @(negedge clk); res_valid = 1'b0; res_ovf = 1'b0; pass_end = 1'b1;
        @(negedge clk); pass_end = 1'b0;
    endtask

    task automatic end_xf();
        @(negedge clk); xform_end = 1'b1;
        @(negedge clk); xform_end = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; grow_mode = 1'b0; xform_start = 1'b0; xform_end = 1'b0;
        pass_start = 1'b0; pass_end = 1'b0; res_valid = 1'b0; res_ovf = 1'b0;
        res_re = '0; res_im = '0;
        repeat (3) @(negedge clk);
        check("R1 shift", int'(pass_shift), 0);
        check("R1 code", int'(scale_code), 0);
        check("R1 done", int'(scale_done), 0);
        check("R1 blank", int'(bins_zero), 0);
        rst_n = 1'b1;

        // Table walk: one 3-bit transform
        start_xf(1'b1);
        check("R4 first pass shift", int'(pass_shift), 0);
        for (int i = 0; i < 7; i++) begin
            run_pass(VEC[i][66:51], VEC[i][50:35], VEC[i][34:19], VEC[i][18:3], 1'b0);
            check("R3 table shift", int'(pass_shift), int'(VEC[i][2:0]));
        end
        end_xf();
        check("R5 code 15", int'(scale_code), 15);
        check("R9 done", int'(scale_done), 1);
        check("R8 no blank", int'(bins_zero), 0);

        // 2-bit mode cap at 14
        start_xf(1'b0);
        check("R9 done cleared", int'(scale_done), 0);
        check("R4 shift cleared", int'(pass_shift), 0);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R6 shift p0", int'(pass_shift), 4);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R6 shift p1", int'(pass_shift), 4);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R6 shift p2", int'(pass_shift), 4);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R6 shift p3 remainder", int'(pass_shift), 2);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R6 shift p4 none", int'(pass_shift), 0);
        end_xf();
        check("R6 code 14", int'(scale_code), 14);

        // 2-bit overflow
        start_xf(1'b0);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b1);
        check("R7 shift zero", int'(pass_shift), 0);
        check("R7 blank", int'(bins_zero), 1);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0);
        check("R7 blank sticky", int'(bins_zero), 1);
        check("R7 later shift zero", int'(pass_shift), 0);
        end_xf();
        check("R7 code 15", int'(scale_code), 15);

        // 3-bit mode ignores the overflow input
        start_xf(1'b1);
        check("R7 blank cleared", int'(bins_zero), 0);
        run_pass(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b1);
        check("R8 shift", int'(pass_shift), 4);
        check("R8 blank", int'(bins_zero), 0);
        end_xf();
        check("R8 code", int'(scale_code), 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule